// File: doc/BRIEF.md
# Programmable Color Space Converter

A three-stage pipelined 3x3 matrix converter for video with 8 bits per component. Each pixel carries three components. A 2-bit mode input picks one of three behaviours. The block can convert RGB to YCbCr, convert YCbCr to RGB, or pass the pixel through untouched. The nine matrix weights are signed fixed-point values. The three offsets (luma, chroma, RGB) are applied before and after the matrix, and which offset goes where depends on the direction of the conversion.

The integrating logic drives the coefficients and offsets as static configuration. It changes them only between frames, while data-enable is low. Horizontal sync, vertical sync and data-enable go through a delay line of the same length as the data path, so timing at the output lines up with the converted pixels.

Top module: `csc_matrix`

## Requirements
- R1: `mode_i` = 2'b10 selects RGB-to-YCbCr and 2'b11 selects YCbCr-to-RGB. Codes 2'b00 and 2'b01 bypass the matrix, so `pix_o` equals the input pixel bit for bit.
- R2: Pixel, `hsync_o`, `vsync_o` and `de_o` all appear exactly three clock cycles after the matching inputs are sampled. The mode is carried along with each pixel.
- R3: Each coefficient is 14-bit two's complement with 11 fractional bits, so 0x0800 is a gain of 1.0. Coefficient k = 3*row + col sits at `coef_i[14k+13:14k]`. Output component `row` is the sum over `col` of coef(row,col) times input component `col`.
- R4: Component k of a pixel sits at bits [8k+7:8k]. In YCbCr, component 0 is luma and components 1 and 2 are chroma.
- R5: For YCbCr-to-RGB, `y_off_i` is subtracted from component 0 and `c_off_i` from components 1 and 2 before the multiply. `rgb_off_i` is added to every output component.
- R6: For RGB-to-YCbCr, `rgb_off_i` is subtracted from every input component. `y_off_i` is added to output component 0 and `c_off_i` to output components 1 and 2.
- R7: The full-precision sum of products is rounded by adding 1024 and shifting right arithmetically by 11, before the output offset is added.
- R8: Each offset-adjusted result is clamped to the range 0 to 255.
- R9: Negative coefficients and negative offset-corrected inputs are handled as signed values.
- R10: While `rst_ni` is low, and until valid data has passed through, `pix_o`, `hsync_o`, `vsync_o` and `de_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Conversion select (R1) |
| coef_i | input | 126 | Nine packed 14-bit coefficients (R3) |
| y_off_i | input | 8 | Luma offset |
| c_off_i | input | 8 | Chroma offset |
| rgb_off_i | input | 8 | RGB offset |
| pix_i | input | 24 | Input pixel, three components (R4) |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Data enable in |
| pix_o | output | 24 | Converted pixel |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed data enable |

## Verification
The rounding and clamping corners are the hardest to reach. A real conversion matrix only rarely lands on exact half-LSB results, or drives a sum far enough below zero or above 255 to saturate. The bench therefore loads a half-gain diagonal matrix, so that odd inputs land exactly on the half step. It also uses limited-range pixels at the extremes of the chroma range, which push the first output component past both clamp limits. Streams with sync patterns that differ on every line check that the delay alignment holds pixel by pixel.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    MODE_BYP0 = 2'b00,
    MODE_BYP1 = 2'b01,
    MODE_R2Y  = 2'b10,
    MODE_Y2R  = 2'b11
  } csc_mode_e;
endpackage

// File: rtl/csc_delay.sv
module csc_delay #(
  parameter int W     = 3,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= (s == 0) ? d_i : stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/csc_pre.sv
module csc_pre #(
  parameter int DW  = 8,
  parameter int NCH = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            mode_i,
  input  logic [NCH*DW-1:0]     pix_i,
  input  logic [DW-1:0]         y_off_i,
  input  logic [DW-1:0]         c_off_i,
  input  logic [DW-1:0]         rgb_off_i,
  output logic [NCH*(DW+1)-1:0] diff_o
);
  import csc_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0]      off;
    logic signed [DW:0] diff;
    always_comb begin
      if (mode_i == MODE_Y2R) off = (c == 0) ? y_off_i : c_off_i;
      else                    off = rgb_off_i;
      diff = $signed({1'b0, pix_i[c*DW +: DW]}) - $signed({1'b0, off});
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) diff_o[c*(DW+1) +: DW+1] <= '0;
      else         diff_o[c*(DW+1) +: DW+1] <= diff;
    end
  end
endmodule

// File: rtl/csc_mac.sv
module csc_mac #(
  parameter int DW  = 8,
  parameter int CW  = 14,
  parameter int NCH = 3,
  parameter int AW  = 25
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH*(DW+1)-1:0] diff_i,
  input  logic [NCH*NCH*CW-1:0] coef_i,
  output logic [NCH*AW-1:0]     acc_o
);
  for (genvar r = 0; r < NCH; r++) begin : g_row
    logic signed [AW-1:0] sum;
    always_comb begin
      sum = '0;
      for (int c = 0; c < NCH; c++) begin
        logic signed [AW-1:0] k;
        logic signed [AW-1:0] x;
        k   = AW'($signed(coef_i[(r*NCH+c)*CW +: CW]));
        x   = AW'($signed(diff_i[c*(DW+1) +: DW+1]));
        sum = sum + k * x;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_o[r*AW +: AW] <= '0;
      else         acc_o[r*AW +: AW] <= sum;
    end
  end
endmodule

// File: rtl/csc_post.sv
module csc_post #(
  parameter int DW   = 8,
  parameter int NCH  = 3,
  parameter int AW   = 25,
  parameter int FRAC = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [NCH*AW-1:0] acc_i,
  input  logic [NCH*DW-1:0] byp_pix_i,
  input  logic [DW-1:0]     y_off_i,
  input  logic [DW-1:0]     c_off_i,
  input  logic [DW-1:0]     rgb_off_i,
  output logic [NCH*DW-1:0] pix_o
);
  import csc_pkg::*;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC-1);
  localparam logic signed [AW-1:0] MAXV = AW'((1 << DW) - 1);

  for (genvar r = 0; r < NCH; r++) begin : g_row
    logic [DW-1:0]        off;
    logic signed [AW-1:0] rnd, val;
    logic [DW-1:0]        res;
    always_comb begin
      if (mode_i == MODE_R2Y) off = (r == 0) ? y_off_i : c_off_i;
      else                    off = rgb_off_i;
      rnd = ($signed(acc_i[r*AW +: AW]) + HALF) >>> FRAC;
      val = rnd + $signed({{(AW-DW){1'b0}}, off});
      if (val < 0)         res = '0;
      else if (val > MAXV) res = '1;
      else                 res = val[DW-1:0];
      if (mode_i == MODE_BYP0 || mode_i == MODE_BYP1) res = byp_pix_i[r*DW +: DW];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pix_o[r*DW +: DW] <= '0;
      else         pix_o[r*DW +: DW] <= res;
    end
  end
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix #(
  parameter int DW   = 8,
  parameter int CW   = 14,
  parameter int FRAC = 11,
  parameter int NCH  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            mode_i,
  input  logic [NCH*NCH*CW-1:0] coef_i,
  input  logic [DW-1:0]         y_off_i,
  input  logic [DW-1:0]         c_off_i,
  input  logic [DW-1:0]         rgb_off_i,
  input  logic [NCH*DW-1:0]     pix_i,
  input  logic                  hsync_i,
  input  logic                  vsync_i,
  input  logic                  de_i,
  output logic [NCH*DW-1:0]     pix_o,
  output logic                  hsync_o,
  output logic                  vsync_o,
  output logic                  de_o
);
  localparam int AW = DW + 1 + CW + $clog2(NCH);
  localparam int PW = 2 + NCH*DW;

  logic [NCH*(DW+1)-1:0] diff;
  logic [NCH*AW-1:0]     acc;
  logic [PW-1:0]         side_q;

  csc_pre #(.DW(DW), .NCH(NCH)) u_pre (
    .clk_i, .rst_ni, .mode_i, .pix_i,
    .y_off_i, .c_off_i, .rgb_off_i, .diff_o(diff)
  );

  csc_mac #(.DW(DW), .CW(CW), .NCH(NCH), .AW(AW)) u_mac (
    .clk_i, .rst_ni, .diff_i(diff), .coef_i, .acc_o(acc)
  );

  // mode and raw pixel follow the two arithmetic stages
  csc_delay #(.W(PW), .DEPTH(2)) u_side (
    .clk_i, .rst_ni, .d_i({mode_i, pix_i}), .q_o(side_q)
  );

  csc_post #(.DW(DW), .NCH(NCH), .AW(AW), .FRAC(FRAC)) u_post (
    .clk_i, .rst_ni, .mode_i(side_q[PW-1 -: 2]), .acc_i(acc),
    .byp_pix_i(side_q[NCH*DW-1:0]),
    .y_off_i, .c_off_i, .rgb_off_i, .pix_o
  );

  csc_delay #(.W(3), .DEPTH(3)) u_sync (
    .clk_i, .rst_ni, .d_i({hsync_i, vsync_i, de_i}),
    .q_o({hsync_o, vsync_o, de_o})
  );
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk #(
  parameter int PW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic [PW-1:0] pix_i,
  input logic          hsync_i,
  input logic          vsync_i,
  input logic          de_i,
  input logic [PW-1:0] pix_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_de_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (de_o == $past(de_i, 3)));

  assert_hsync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (hsync_o == $past(hsync_i, 3)));

  assert_vsync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (vsync_o == $past(vsync_i, 3)));

  assert_bypass_exact_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(mode_i, 3) < 2'd2) |-> (pix_o == $past(pix_i, 3)));

  assert_reset_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd0) |-> (de_o == 1'b0 && pix_o == '0));
endmodule

bind csc_matrix csc_matrix_chk #(.PW(NCH*DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pix_i(pix_i),
  .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
  .pix_o(pix_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
);

// File: tb/csc_matrix_bench.sv
`timescale 1ns/1ps
module csc_matrix_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [125:0] coef_i = '0;
  logic [7:0]   y_off_i = 8'h10, c_off_i = 8'h80, rgb_off_i = 8'h00;
  logic [23:0]  pix_i = '0;
  logic         hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic [23:0]  pix_o;
  logic         hsync_o, vsync_o, de_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  csc_matrix u_csc_matrix (
    .clk_i, .rst_ni, .mode_i, .coef_i, .y_off_i, .c_off_i, .rgb_off_i,
    .pix_i, .hsync_i, .vsync_i, .de_i, .pix_o, .hsync_o, .vsync_o, .de_o
  );

  function automatic logic [125:0] pack_coef(input int m [9]);
    logic [125:0] v;
    v = '0;
    for (int k = 0; k < 9; k++) v[k*14 +: 14] = 14'(m[k]);
    return v;
  endfunction

  function automatic logic [23:0] model(input logic [1:0] md, input logic [23:0] p,
                                        input logic [125:0] cf, input logic [7:0] yo,
                                        input logic [7:0] co, input logic [7:0] ro);
    logic [23:0] res;
    if (!md[1]) return p;
    res = '0;
    for (int r = 0; r < 3; r++) begin
      longint s, v, oo;
      s = 0;
      for (int c = 0; c < 3; c++) begin
        longint k, io;
        logic signed [13:0] k14;
        k14 = cf[(r*3+c)*14 +: 14];
        k   = longint'(k14);
        io  = (md == 2'b11) ? ((c == 0) ? longint'(yo) : longint'(co)) : longint'(ro);
        s   = s + k * (longint'(p[8*c +: 8]) - io);
      end
      oo = (md == 2'b10) ? ((r == 0) ? longint'(yo) : longint'(co)) : longint'(ro);
      v  = ((s + 1024) >>> 11) + oo;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      res[8*r +: 8] = 8'(v);
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    de_i = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0; pix_i = '0;
  endtask

  // streams n pixels back to back, checks each three cycles later
  task automatic run_stream(input logic [1:0] md, input int n, input int seed, input string req);
    logic [23:0] exp_p [16];
    logic [2:0]  exp_s [16];
    mode_i = md;
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk_i);
      if (i >= 3) begin
        check(req, pix_o, exp_p[i-3]);
        check("R2 sync", {21'd0, hsync_o, vsync_o, de_o}, {21'd0, exp_s[i-3]});
      end
      if (i < n) begin
        pix_i   = {8'(seed*53 + i*97), 8'(seed*29 + i*61 + 7), 8'(seed*17 + i*131 + 3)};
        hsync_i = (i % 5 == 0);
        vsync_i = (i % 7 == 3);
        de_i    = (i % 3 != 2);
        exp_p[i] = model(md, pix_i, coef_i, y_off_i, c_off_i, rgb_off_i);
        exp_s[i] = {hsync_i, vsync_i, de_i};
      end else idle();
    end
  endtask

  task automatic one_px(input logic [1:0] md, input logic [23:0] p, output logic [23:0] got);
    @(negedge clk_i);
    mode_i = md; pix_i = p; de_i = 1'b1;
    @(negedge clk_i);
    idle();
    repeat (2) @(negedge clk_i);
    got = pix_o;
  endtask

  task automatic t_reset();
    check("R10 pix", pix_o, 24'h0);
    check("R10 sync", {21'd0, hsync_o, vsync_o, de_o}, 24'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 after release", {pix_o[23:3], hsync_o, vsync_o, de_o}, 24'h0);
  endtask

  task automatic t_bypass();
    int m [9] = '{1, -2, 3, -4, 5, -6, 7, -8, 9};
    coef_i = pack_coef(m);
    run_stream(2'b00, 8, 1, "R1 bypass00");
    run_stream(2'b01, 8, 2, "R1 bypass01");
  endtask

  task automatic t_unity();
    int m [9] = '{2048, 0, 0, 0, 2048, 0, 0, 0, 2048};
    logic [23:0] got;
    coef_i = pack_coef(m);
    y_off_i = 0; c_off_i = 0; rgb_off_i = 0;
    one_px(2'b10, 24'hA5_3C_F0, got);
    check("R3 unity", got, 24'hA5_3C_F0);
    run_stream(2'b11, 6, 3, "R3 R4 unity stream");
  endtask

  task automatic t_y2r();
    int m [9] = '{2383, 0, 3269, 2383, -803, -1665, 2383, 4131, 0};
    coef_i = pack_coef(m);
    y_off_i = 8'h10; c_off_i = 8'h80; rgb_off_i = 8'h00;
    run_stream(2'b11, 12, 4, "R5 R9 ycbcr to rgb");
    rgb_off_i = 8'h10;
    run_stream(2'b11, 10, 5, "R5 rgb offset added");
  endtask

  task automatic t_r2y();
    int m [9] = '{1202, 612, 233, -339, -694, 1033, 1033, -865, -168};
    coef_i = pack_coef(m);
    y_off_i = 8'h10; c_off_i = 8'h80; rgb_off_i = 8'h00;
    run_stream(2'b10, 12, 6, "R6 R9 rgb to ycbcr");
    rgb_off_i = 8'h08;
    run_stream(2'b10, 10, 7, "R6 rgb offset removed");
  endtask

  task automatic t_round();
    int m [9] = '{1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
    logic [23:0] got;
    coef_i = pack_coef(m);
    y_off_i = 0; c_off_i = 0; rgb_off_i = 0;
    one_px(2'b10, {8'd5, 8'd3, 8'd1}, got);
    check("R7 half up", got, {8'd3, 8'd2, 8'd1});
    one_px(2'b10, {8'd254, 8'd2, 8'd0}, got);
    check("R7 exact", got, {8'd127, 8'd1, 8'd0});
  endtask

  task automatic t_clamp();
    int m [9] = '{2383, 0, 3269, 2383, -803, -1665, 2383, 4131, 0};
    logic [23:0] got;
    coef_i = pack_coef(m);
    y_off_i = 8'h10; c_off_i = 8'h80; rgb_off_i = 8'h00;
    one_px(2'b11, {8'd240, 8'd128, 8'd235}, got);
    check("R8 high", {16'd0, got[7:0]}, 24'd255);
    check("R8 high model", got, model(2'b11, {8'd240, 8'd128, 8'd235}, coef_i, 8'h10, 8'h80, 8'h00));
    one_px(2'b11, {8'd16, 8'd128, 8'd16}, got);
    check("R8 low", {16'd0, got[7:0]}, 24'd0);
    check("R8 low model", got, model(2'b11, {8'd16, 8'd128, 8'd16}, coef_i, 8'h10, 8'h80, 8'h00));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_vec++; n_bad++;
    $display("FAIL R2 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_bypass();
    t_unity();
    t_y2r();
    t_r2y();
    t_round();
    t_clamp();
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule